// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Triggers

This block is a single general-purpose I/O port of up to eight pins. Software reaches it through a flat register bus made of address, write enable, write data and a combinational read data return. Every pin owns a 32-byte register window. In that window software enables the pin and picks its direction. It can also let the pin float, set the level driven onto it, program an input debounce threshold, arm an interrupt detector and acknowledge latched interrupts.

Each input is resynchronised through two flops and then filtered by a per-pin debounce counter. The filtered level feeds both the input register and the trigger detector. The detector senses a level, a single edge of a chosen direction, or both edges. A port-wide status word collects the reportable pending bits. The logical OR of those bits drives one interrupt line toward the system interrupt controller.

Top module: `gtp_port`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, no pin is driven (`pin_oe` all 0) and `irq` is 0.
- R2: Pin p's window starts at p*0x20 and holds config at +0x00, debounce at +0x04, input at +0x08, output control at +0x0C, output value at +0x10 and interrupt clear at +0x14. Config bits 0 (enable), 1 (direction, 1 = output), 3:2 (trigger type), 4 (polarity) and 6 (interrupt enable) read back as written, and its other bits read 0. Debounce bits 7:0 read back as written. Output control bit 0 and output value bit 0 read back as written.
- R3: `pin_oe[p]` is 1 exactly when the pin is enabled, set to output and output control bit 0 (float) is 0. `pin_out[p]` equals output value bit 0.
- R4: Input register bit 0 shows the filtered pin level. With threshold T>0, a new level must be stable for T+1 clocks after the two-flop synchroniser. A clean change on `pin_in` first reads back T+3 clocks after it is applied. A pulse shorter than that is discarded.
- R5: With threshold 0 the debounce is bypassed, and a change reads back 3 clocks after it is applied.
- R6: Trigger type 1 (level) with polarity 1 is pending while the filtered level is high, and with polarity 0 while it is low. A clear does not remove it while the level is still active.
- R7: Trigger type 2 (single edge) latches on a rising edge when polarity is 1, and on a falling edge when polarity is 0. The opposite edge is ignored and the latch holds until cleared.
- R8: Trigger type 3 (double edge) latches on both edges, whatever the polarity bit says.
- R9: Writing a value with bit 0 set to a pin's clear register drops that pin's edge latch. Writing bit 0 as 0 has no effect.
- R10: Status register at 0x104 has bit n = pending of pin n. It reads 1 only while both the enable bit and the interrupt enable bit are set, and masking does not discard a latched edge.
- R11: `irq` is 1 exactly when at least one status bit is 1.
- R12: Trigger type 0 (none) never produces a pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Raw pad input levels, asynchronous |
| pin_out | output | NUM_PINS | Level to drive on each pad |
| pin_oe | output | NUM_PINS | Output driver enable per pad |
| irq | output | 1 | Combined port interrupt |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before checking starts. They also assume that a bus write lasts exactly one cycle, so a clear strobe and a configuration change never overlap the cycle they are judged in. The bench drives every bus access and every pad change on the falling clock edge, with one write per task call and the address held stable around it. Random configuration values cover every trigger type and polarity. During that phase the pads stay at 0, and the interrupt behaviour is then exercised by directed pad sequences with known debounce settings.

// File: rtl/gtp_pkg.sv
// Shared types and register layout for the GPIO trigger port.
// Assumes a 9-bit byte address: per-pin windows below 0x100, status above.
package gtp_pkg;

    typedef enum logic [1:0] {
        TRIG_OFF   = 2'd0,
        TRIG_LEVEL = 2'd1,
        TRIG_EDGE  = 2'd2,
        TRIG_BOTH  = 2'd3
    } trig_e;

    typedef struct packed {
        logic  ie;
        logic  pol;
        trig_e trig;
        logic  dir;
        logic  en;
    } pin_cfg_t;

    localparam int WIN_LSB = 5;
    localparam logic [4:0] OFS_CFG  = 5'h00;
    localparam logic [4:0] OFS_DBNC = 5'h04;
    localparam logic [4:0] OFS_IN   = 5'h08;
    localparam logic [4:0] OFS_OCTL = 5'h0C;
    localparam logic [4:0] OFS_OVAL = 5'h10;
    localparam logic [4:0] OFS_ICLR = 5'h14;
    localparam int STATUS_OFS = 'h104;

endpackage

// File: rtl/gtp_in_filter.sv
// Two-flop synchroniser followed by a stability counter.
// Assumes thresh is quasi-static; a threshold of zero passes the synced level straight on.
module gtp_in_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_raw,
    input  logic [CNT_W-1:0] thresh,
    output logic             sync_out,
    output logic             level
);
    logic             meta_q;
    logic             sync_q;
    logic [CNT_W-1:0] cnt_q;

    // Bring the asynchronous pad level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= pin_raw;
            sync_q <= meta_q;
        end
    end

    // Accept a new level only after it has persisted thresh+1 clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
            cnt_q <= '0;
        end else if (thresh == '0) begin
            level <= sync_q;
            cnt_q <= '0;
        end else if (sync_q == level) begin
            cnt_q <= '0;
        end else if (cnt_q == thresh) begin
            level <= sync_q;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sync_out = sync_q;

endmodule

// File: rtl/gtp_irq_detect.sv
// Per-pin trigger detector: level, single edge or double edge.
// Assumes level is already synchronous; an edge event wins over a same-cycle clear.
module gtp_irq_detect
    import gtp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  level,
    input  trig_e trig,
    input  logic  pol,
    input  logic  clr,
    output logic  pend
);
    logic prev_q;
    logic rise;
    logic fall;
    logic hit;

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;

    // Decide whether this cycle carries a qualifying edge.
    always_comb begin
        case (trig)
            TRIG_EDGE: hit = pol ? rise : fall;
            TRIG_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end

    // Track the previous level and update the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= level;
            case (trig)
                TRIG_OFF:   pend <= 1'b0;
                TRIG_LEVEL: pend <= (level == pol);
                default: begin
                    if (hit)      pend <= 1'b1;
                    else if (clr) pend <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/gtp_port.sv
// GPIO port of up to eight pins with per-pin register windows and trigger detection.
// Assumes single-cycle writes, NUM_PINS <= 8 and ADDR_W = 9 so status sits at 0x104.
module gtp_port
    import gtp_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 32,
    parameter int DBNC_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int WIN_W = ADDR_W - WIN_LSB;
    localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);

    pin_cfg_t            cfg_q  [NUM_PINS];
    logic [DBNC_W-1:0]   dbnc_q [NUM_PINS];
    logic [NUM_PINS-1:0] flt_q;
    logic [NUM_PINS-1:0] oval_q;

    logic [NUM_PINS-1:0]   clr_v;
    logic [NUM_PINS-1:0]   lvl_v;
    logic [NUM_PINS-1:0]   sync_v;
    logic [NUM_PINS-1:0]   pend_v;
    logic [NUM_PINS-1:0]   pol_v;
    logic [2*NUM_PINS-1:0] trig_v;
    logic [NUM_PINS-1:0]   status;

    logic [WIN_W-1:0] win;
    logic [4:0]       ofs;
    logic             unused_wdata;

    assign win          = bus_addr[ADDR_W-1:WIN_LSB];
    assign ofs          = bus_addr[WIN_LSB-1:0];
    assign unused_wdata = ^bus_wdata[DATA_W-1:DBNC_W];

    // Register writes for every pin window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                cfg_q[p]  <= '0;
                dbnc_q[p] <= '0;
            end
            flt_q  <= '0;
            oval_q <= '0;
        end else if (bus_we) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (win == WIN_W'(p)) begin
                    case (ofs)
                        OFS_CFG: begin
                            cfg_q[p].en   <= bus_wdata[0];
                            cfg_q[p].dir  <= bus_wdata[1];
                            cfg_q[p].trig <= trig_e'(bus_wdata[3:2]);
                            cfg_q[p].pol  <= bus_wdata[4];
                            cfg_q[p].ie   <= bus_wdata[6];
                        end
                        OFS_DBNC: dbnc_q[p] <= bus_wdata[DBNC_W-1:0];
                        OFS_OCTL: flt_q[p]  <= bus_wdata[0];
                        OFS_OVAL: oval_q[p] <= bus_wdata[0];
                        default: ;
                    endcase
                end
            end
        end
    end

    // Clear strobes: one cycle, only when bit 0 of the data is set.
    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            clr_v[p] = bus_we && (win == WIN_W'(p)) && (ofs == OFS_ICLR) && bus_wdata[0];
        end
    end

    generate
        for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
            gtp_in_filter #(.CNT_W(DBNC_W)) u_filt (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_raw  (pin_in[g]),
                .thresh   (dbnc_q[g]),
                .sync_out (sync_v[g]),
                .level    (lvl_v[g])
            );

            gtp_irq_detect u_det (
                .clk   (clk),
                .rst_n (rst_n),
                .level (lvl_v[g]),
                .trig  (cfg_q[g].trig),
                .pol   (cfg_q[g].pol),
                .clr   (clr_v[g]),
                .pend  (pend_v[g])
            );

            assign trig_v[2*g +: 2] = cfg_q[g].trig;
            assign pol_v[g]   = cfg_q[g].pol;
            assign status[g]  = pend_v[g] & cfg_q[g].en & cfg_q[g].ie;
            assign pin_oe[g]  = cfg_q[g].en & cfg_q[g].dir & ~flt_q[g];
            assign pin_out[g] = oval_q[g];
        end
    endgenerate

    assign irq = |status;

    // Combinational read mux over the status word and the pin windows.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == STATUS_A) begin
            bus_rdata[NUM_PINS-1:0] = status;
        end else begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (win == WIN_W'(p)) begin
                    case (ofs)
                        OFS_CFG: begin
                            bus_rdata[0]   = cfg_q[p].en;
                            bus_rdata[1]   = cfg_q[p].dir;
                            bus_rdata[3:2] = cfg_q[p].trig;
                            bus_rdata[4]   = cfg_q[p].pol;
                            bus_rdata[6]   = cfg_q[p].ie;
                        end
                        OFS_DBNC: bus_rdata[DBNC_W-1:0] = dbnc_q[p];
                        OFS_IN:   bus_rdata[0] = lvl_v[p];
                        OFS_OCTL: bus_rdata[0] = flt_q[p];
                        OFS_OVAL: bus_rdata[0] = oval_q[p];
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/gtp_port_checker.sv
// Temporal checks on the GPIO trigger port, attached by bind.
// Assumes reset is asserted at the first clock edge.
module gtp_port_checker #(
    parameter int NUM_PINS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PINS-1:0]   pin_oe,
    input logic                  irq,
    input logic [NUM_PINS-1:0]   pend,
    input logic [NUM_PINS-1:0]   lvl,
    input logic [NUM_PINS-1:0]   sync,
    input logic [2*NUM_PINS-1:0] trig,
    input logic [NUM_PINS-1:0]   pol,
    input logic [NUM_PINS-1:0]   clr
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (pin_oe == '0 && !irq)); // R1

    generate
        for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
            AST_FILTER_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
                (lvl[g] != $past(lvl[g])) |-> ($past(sync[g]) == lvl[g])); // R4
            AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                (trig[2*g +: 2] == 2'd1) |=> (pend[g] == $past(lvl[g] == pol[g]))); // R6
            AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (pend[g] && trig[2*g+1] && !clr[g]) |=> pend[g]); // R7
            AST_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                (trig[2*g +: 2] == 2'd0) |=> !pend[g]); // R12
        end
    endgenerate

endmodule

bind gtp_port gtp_port_checker #(.NUM_PINS(NUM_PINS)) u_gtp_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_oe (pin_oe),
    .irq    (irq),
    .pend   (pend_v),
    .lvl    (lvl_v),
    .sync   (sync_v),
    .trig   (trig_v),
    .pol    (pol_v),
    .clr    (clr_v)
);

// File: tb/gtp_port_bench.sv
module gtp_port_bench;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out;
    logic [N-1:0] pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    gtp_port u_gtp_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic logic [8:0] adr(int p, logic [4:0] ofs);
        return 9'(p * 32) + 9'(ofs);
    endfunction

    function automatic logic exp_oe(logic [31:0] cfg, logic flt);
        return cfg[0] & cfg[1] & ~flt;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic peek(logic [8:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd(logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pin_in = '0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1: reset state
        rd(adr(0, 5'h00), d); chk("R1 cfg pin0", d, 0);
        rd(adr(7, 5'h04), d); chk("R1 dbnc pin7", d, 0);
        rd(9'h104, d);        chk("R1 status", d, 0);
        chk("R1 pin_oe", 32'(pin_oe), 0);
        chk("R1 irq", 32'(irq), 0);

        // R2 / R3: random configuration, read-back and drive model
        for (int i = 0; i < 40; i++) begin
            int p;
            logic [31:0] cfgw, th;
            logic fl, ov;
            p = int'($urandom % N);
            cfgw = $urandom;
            th = $urandom & 32'hFF;
            fl = 1'($urandom);
            ov = 1'($urandom);
            wr(adr(p, 5'h00), cfgw);
            wr(adr(p, 5'h04), th | 32'hA500);
            wr(adr(p, 5'h0C), 32'(fl));
            wr(adr(p, 5'h10), 32'(ov));
            rd(adr(p, 5'h00), d); chk("R2 cfg readback", d, cfgw & 32'h5F);
            rd(adr(p, 5'h04), d); chk("R2 dbnc readback", d, th);
            rd(adr(p, 5'h0C), d); chk("R2 octl readback", d, 32'(fl));
            rd(adr(p, 5'h10), d); chk("R2 oval readback", d, 32'(ov));
            chk("R3 pin_oe", 32'(pin_oe[p]), 32'(exp_oe(cfgw, fl)));
            chk("R3 pin_out", 32'(pin_out[p]), 32'(ov));
        end

        do_reset();
        rd(adr(3, 5'h00), d); chk("R1 cfg after re-reset", d, 0);

        // R3 directed
        wr(adr(0, 5'h00), 32'h03);
        wr(adr(0, 5'h10), 32'h1);
        wait_cyc(1);
        chk("R3 driven oe", 32'(pin_oe[0]), 1);
        chk("R3 driven level", 32'(pin_out[0]), 1);
        wr(adr(0, 5'h0C), 32'h1);
        wait_cyc(1);
        chk("R3 floated oe", 32'(pin_oe[0]), 0);
        wr(adr(0, 5'h0C), 32'h0);
        wr(adr(0, 5'h00), 32'h01);
        wait_cyc(1);
        chk("R3 input dir oe", 32'(pin_oe[0]), 0);

        // R5: threshold 0 bypass timing on pin 0
        @(negedge clk); pin_in[0] = 1'b1;
        wait_cyc(2); peek(adr(0, 5'h08), d); chk("R5 before 3 clocks", d, 0);
        wait_cyc(1); peek(adr(0, 5'h08), d); chk("R5 at 3 clocks", d, 1);

        // R4: threshold 3 on pin 1
        wr(adr(1, 5'h04), 32'd3);
        @(negedge clk); pin_in[1] = 1'b1;
        wait_cyc(5); peek(adr(1, 5'h08), d); chk("R4 before T+3", d, 0);
        wait_cyc(1); peek(adr(1, 5'h08), d); chk("R4 at T+3", d, 1);
        @(negedge clk); pin_in[1] = 1'b0;
        wait_cyc(2); pin_in[1] = 1'b1;
        wait_cyc(10); peek(adr(1, 5'h08), d); chk("R4 glitch rejected", d, 1);

        // R6: level high on pin 2
        wr(adr(2, 5'h00), 32'h55);
        @(negedge clk); pin_in[2] = 1'b1;
        wait_cyc(6);
        rd(9'h104, d); chk("R6 level active", d, 32'h04);
        chk("R11 irq with level", 32'(irq), 1);
        wr(adr(2, 5'h14), 32'h1);
        wait_cyc(2);
        rd(9'h104, d); chk("R6 clear while active", d, 32'h04);
        pin_in[2] = 1'b0;
        wait_cyc(6);
        rd(9'h104, d); chk("R6 level gone", d, 0);
        chk("R11 irq low", 32'(irq), 0);

        // R7 / R9: rising edge on pin 3
        wr(adr(3, 5'h00), 32'h59);
        @(negedge clk); pin_in[3] = 1'b1;
        wait_cyc(6);
        rd(9'h104, d); chk("R7 rise latched", d, 32'h08);
        pin_in[3] = 1'b0;
        wait_cyc(6);
        rd(9'h104, d); chk("R7 held after fall", d, 32'h08);
        wr(adr(3, 5'h14), 32'h0);
        rd(9'h104, d); chk("R9 clear with bit0=0", d, 32'h08);
        wr(adr(3, 5'h14), 32'h1);
        rd(9'h104, d); chk("R9 clear drops latch", d, 0);
        pin_in[3] = 1'b1;
        wait_cyc(6);
        wr(adr(3, 5'h14), 32'h1);
        pin_in[3] = 1'b0;
        wait_cyc(6);
        rd(9'h104, d); chk("R7 fall ignored with pol=1", d, 0);

        // R7: falling edge on pin 4
        wr(adr(4, 5'h00), 32'h49);
        @(negedge clk); pin_in[4] = 1'b1;
        wait_cyc(6);
        rd(9'h104, d); chk("R7 rise ignored with pol=0", d, 0);
        pin_in[4] = 1'b0;
        wait_cyc(6);
        rd(9'h104, d); chk("R7 fall latched", d, 32'h10);
        wr(adr(4, 5'h14), 32'h1);

        // R8: double edge on pin 5, polarity bit set
        wr(adr(5, 5'h00), 32'h5D);
        @(negedge clk); pin_in[5] = 1'b1;
        wait_cyc(6);
        rd(9'h104, d); chk("R8 rise latched", d, 32'h20);
        wr(adr(5, 5'h14), 32'h1);
        pin_in[5] = 1'b0;
        wait_cyc(6);
        rd(9'h104, d); chk("R8 fall latched", d, 32'h20);
        wr(adr(5, 5'h14), 32'h1);

        // R10: masking and enable gating on pin 6
        wr(adr(6, 5'h00), 32'h19);
        @(negedge clk); pin_in[6] = 1'b1;
        wait_cyc(6);
        rd(9'h104, d); chk("R10 ie off hides", d, 0);
        chk("R10 irq hidden", 32'(irq), 0);
        wr(adr(6, 5'h00), 32'h58);
        rd(9'h104, d); chk("R10 pin disabled hides", d, 0);
        wr(adr(6, 5'h00), 32'h59);
        rd(9'h104, d); chk("R10 latched edge shows", d, 32'h40);

        // R11: OR of two sources
        wr(adr(2, 5'h00), 32'h55);
        @(negedge clk); pin_in[2] = 1'b1;
        wait_cyc(6);
        rd(9'h104, d); chk("R11 two pending", d, 32'h44);
        wr(adr(6, 5'h14), 32'h1);
        rd(9'h104, d); chk("R11 one left", d, 32'h04);
        chk("R11 irq one left", 32'(irq), 1);
        pin_in[2] = 1'b0;
        wait_cyc(6);
        chk("R11 irq none", 32'(irq), 0);

        // R12: type none on pin 7
        wr(adr(7, 5'h00), 32'h51);
        @(negedge clk); pin_in[7] = 1'b1;
        wait_cyc(6);
        pin_in[7] = 1'b0;
        wait_cyc(6);
        rd(9'h104, d); chk("R12 none stays quiet", d, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule